// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block drives an external asynchronous static-memory style bus that serves up to four banks, each with its own active-low chip-select line. An internal client hands it one request at a time: a read or write flag, a bank number, an offset inside the bank and, for writes, a data word. The block then walks a fixed sequence of phases on the external pins. Address setup comes first, then chip-select setup, then the access strobe, then chip-select hold and finally address hold. Each phase length comes from a per-bank timing register. Read data comes back on a response port, one pulse per data item.

Each bank is configured through a plain register-write port. The configuration word sets five phase counts plus a page-beat count. It also has a page-mode enable, which makes a read fetch four consecutive items, and a width bit that selects an 8-bit or 16-bit data item. The request side is a valid/ready stream. The response side has no back-pressure: a response pulse is produced exactly once and the client must take it in that cycle. The configuration port is a simple write strobe.

Top module: `smc_bank_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, `req_ready` is 1, every `mem_cs_n` bit is 1, `mem_oe_n` and `mem_we_n` are 1, `mem_data_oe` is 0, `mem_addr` is 0 and `rsp_valid` is 0. No chip-select is ever asserted while `req_ready` is 1.
- R2: A cycle with `cfg_we` high loads `cfg_word` into the configuration of bank `cfg_bank`. The bit fields are: [4:0] access count A, [8:5] address-setup count S, [12:9] chip-select-setup count C, [16:13] chip-select-hold count H, [20:17] address-hold count D, [24:21] page-beat count P, [25] page enable, [26] width (1 = 16-bit items, 0 = 8-bit items). After reset every field is 0.
- R3: In the cycle after a request is accepted, the sequence begins. The phases run in this order:
  - S cycles with the address driven and chip-select high;
  - C cycles with chip-select low and both strobes high;
  - A+1 access cycles with chip-select and the strobe low;
  - H cycles with chip-select low and both strobes high;
  - D cycles with chip-select high and the address still driven.
  
  A phase whose count is 0 takes no cycle.
- R4: The chip-select driven low is `mem_cs_n[req_bank]`. At most one chip-select bit is low in any cycle.
- R5: In a write, `mem_we_n` takes the place of `mem_oe_n`. `mem_data_oe` is 1 and `mem_wdata` holds the accepted write data from the first sequence cycle through the last hold cycle. Outside writes, `mem_data_oe` is 0 and `mem_wdata` is 0.
- R6: A read samples `mem_rdata` on the last cycle of each access or page beat. In the next cycle, `rsp_valid` is 1 for exactly one cycle with that value on `rsp_data`. There is no back-pressure on the response.
- R7: With page enable set, a read performs four beats. The first beat lasts A+1 cycles. Each later beat lasts P cycles, and a P of 0 counts as 1. Beat k drives address offset + k·step. The last beat's address stays driven through both hold phases.
- R8: The step is 2 for 16-bit banks and 1 for 8-bit banks. On 8-bit banks, the upper byte of `rsp_data` and of `mem_wdata` is 0.
- R9: A request is accepted only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the first sequence cycle through the last hold cycle. While it is 0, `req_valid` and the request fields have no effect on the pins.
- R10: The bank's configuration is captured when a request is accepted. A configuration write made during a transaction changes only later requests.
- R11: A write always moves a single item, even on a bank with page enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank whose configuration is written |
| cfg_word | input | 27 | Configuration word (fields in R2) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_offset | input | 16 | Byte offset inside the bank |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_data | output | 16 | Read data item |
| mem_cs_n | output | 4 | Active-low chip-selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 16 | External address |
| mem_wdata | output | 16 | External write data |
| mem_data_oe | output | 1 | Write data bus enable |
| mem_rdata | input | 16 | External read data |

## Verification
The hardest state to reach from the ports is a configuration change that lands on the same bank while that bank's transaction is still running. A second hard case is a request held valid while the sequencer is busy. Both need stimulus placed at exact cycles after acceptance. The bench issues a long transaction and then, in the following cycles, writes new timing to the same bank or holds `req_valid` high toward another bank. The per-cycle model must show the old trace unchanged, and the follow-on request must use the new timing. Page reads with every setup and hold count at zero are also driven. These push response pulses into back-to-back cycles and into the idle cycle that follows the sequence.

// File: rtl/smc_pkg.sv
package smc_pkg;

  // Per-bank configuration, MSB first; layout is visible at the cfg_word port.
  typedef struct packed {
    logic       wide;     // 1: 16-bit items
    logic       page_en;  // four-beat page reads
    logic [3:0] t_page;   // later page beat length (0 means 1)
    logic [3:0] t_ahold;  // address hold after chip-select release
    logic [3:0] t_chold;  // chip-select hold after strobe release
    logic [3:0] t_csu;    // chip-select setup before strobe
    logic [3:0] t_asu;    // address setup before chip-select
    logic [4:0] t_acc;    // access length minus one
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASU,
    PH_CSU,
    PH_ACC,
    PH_PAGE,
    PH_CHO,
    PH_AHO
  } phase_e;

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  bank_cfg_t         wr_cfg,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);

  bank_cfg_t regs_q [NUM_BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) regs_q[b] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (wr_bank == BANK_W'(b)) regs_q[b] <= wr_cfg;
    end
  end

  assign rd_cfg = regs_q[rd_bank];

endmodule

// File: rtl/smc_phase_ctl.sv
module smc_phase_ctl
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 16,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [OFS_W-1:0]  start_ofs,
  input  bank_cfg_t         start_cfg,
  output phase_e            phase_o,
  output logic [1:0]        beat_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              wr_o,
  output bank_cfg_t         cfg_o,
  output logic              beat_end_o
);

  phase_e            phase_q, first_ph, next_ph;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        beat_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              wr_q;
  bank_cfg_t         cfg_q;

  function automatic logic [CNT_W-1:0] ph_len(phase_e p, bank_cfg_t c);
    case (p)
      PH_ASU:  return CNT_W'(c.t_asu);
      PH_CSU:  return CNT_W'(c.t_csu);
      PH_ACC:  return CNT_W'(c.t_acc) + CNT_W'(1);
      PH_PAGE: return (c.t_page == 4'd0) ? CNT_W'(1) : CNT_W'(c.t_page);
      PH_CHO:  return CNT_W'(c.t_chold);
      PH_AHO:  return CNT_W'(c.t_ahold);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic phase_e ph_succ(phase_e p, bank_cfg_t c, logic wr, logic [1:0] bt);
    case (p)
      PH_IDLE: return PH_ASU;
      PH_ASU:  return PH_CSU;
      PH_CSU:  return PH_ACC;
      PH_ACC, PH_PAGE:
        return (!wr && c.page_en && bt != 2'd3) ? PH_PAGE : PH_CHO;
      PH_CHO:  return PH_AHO;
      default: return PH_IDLE;
    endcase
  endfunction

  // Skip phases whose programmed length is zero (at most three in a row).
  function automatic phase_e ph_live(phase_e p, bank_cfg_t c, logic wr, logic [1:0] bt);
    phase_e q;
    q = p;
    for (int i = 0; i < 3; i++)
      if (q != PH_IDLE && ph_len(q, c) == '0) q = ph_succ(q, c, wr, bt);
    return q;
  endfunction

  always_comb begin
    first_ph = ph_live(PH_ASU, start_cfg, start_wr, 2'd0);
    next_ph  = ph_live(ph_succ(phase_q, cfg_q, wr_q, beat_q), cfg_q, wr_q, beat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      bank_q  <= '0;
      ofs_q   <= '0;
      wr_q    <= 1'b0;
      cfg_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_q <= first_ph;
        cnt_q   <= ph_len(first_ph, start_cfg) - CNT_W'(1);
        beat_q  <= '0;
        bank_q  <= start_bank;
        ofs_q   <= start_ofs;
        wr_q    <= start_wr;
        cfg_q   <= start_cfg;
      end
    end else if (cnt_q == '0) begin
      phase_q <= next_ph;
      cnt_q   <= ph_len(next_ph, cfg_q) - CNT_W'(1);
      if (next_ph == PH_PAGE) beat_q <= beat_q + 2'd1;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign phase_o    = phase_q;
  assign beat_o     = beat_q;
  assign bank_o     = bank_q;
  assign ofs_o      = ofs_q;
  assign wr_o       = wr_q;
  assign cfg_o      = cfg_q;
  assign beat_end_o = (phase_q == PH_ACC || phase_q == PH_PAGE) && cnt_q == '0;

endmodule

// File: rtl/smc_pin_drive.sv
module smc_pin_drive
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 16,
  parameter int DATA_W    = 16,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  phase_e             phase,
  input  logic [1:0]         beat,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFS_W-1:0]   ofs,
  input  logic               wr,
  input  logic               wide,
  input  logic [DATA_W-1:0]  wdata_q,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic               oe_n,
  output logic               we_n,
  output logic [OFS_W-1:0]   addr,
  output logic [DATA_W-1:0]  wdata,
  output logic               data_oe
);

  logic cs_on, strobe_on, busy;
  logic [OFS_W-1:0] beat_ofs;

  assign busy      = (phase != PH_IDLE);
  assign cs_on     = (phase == PH_CSU) || (phase == PH_ACC) ||
                     (phase == PH_PAGE) || (phase == PH_CHO);
  assign strobe_on = (phase == PH_ACC) || (phase == PH_PAGE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_n[b] = !(cs_on && bank == BANK_W'(b));
  end

  assign oe_n = !(strobe_on && !wr);
  assign we_n = !(strobe_on && wr);

  assign beat_ofs = wide ? OFS_W'({beat, 1'b0}) : OFS_W'(beat);
  assign addr     = busy ? ofs + beat_ofs : '0;
  assign data_oe  = busy && wr;
  assign wdata    = data_oe ? wdata_q : '0;

endmodule

// File: rtl/smc_bank_seq.sv
module smc_bank_seq
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 16,
  parameter int DATA_W    = 16,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [BANK_W-1:0]    cfg_bank,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [OFS_W-1:0]     req_offset,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  output logic [NUM_BANKS-1:0] mem_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [OFS_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic                 mem_data_oe,
  input  logic [DATA_W-1:0]    mem_rdata
);

  bank_cfg_t         sel_cfg, act_cfg;
  phase_e            phase;
  logic [1:0]        beat;
  logic [BANK_W-1:0] act_bank;
  logic [OFS_W-1:0]  act_ofs;
  logic              act_wr, beat_end, accept;
  logic [DATA_W-1:0] wdata_q, rsp_data_q;
  logic              rsp_valid_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  smc_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_bank (cfg_bank),
    .wr_cfg  (bank_cfg_t'(cfg_word)),
    .rd_bank (req_bank),
    .rd_cfg  (sel_cfg)
  );

  smc_phase_ctl #(.NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_wr   (req_write),
    .start_bank (req_bank),
    .start_ofs  (req_offset),
    .start_cfg  (sel_cfg),
    .phase_o    (phase),
    .beat_o     (beat),
    .bank_o     (act_bank),
    .ofs_o      (act_ofs),
    .wr_o       (act_wr),
    .cfg_o      (act_cfg),
    .beat_end_o (beat_end)
  );

  smc_pin_drive #(.NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_pins (
    .phase   (phase),
    .beat    (beat),
    .bank    (act_bank),
    .ofs     (act_ofs),
    .wr      (act_wr),
    .wide    (act_cfg.wide),
    .wdata_q (wdata_q),
    .cs_n    (mem_cs_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .data_oe (mem_data_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (accept)
        wdata_q <= sel_cfg.wide ? req_wdata
                                : {{(DATA_W-HALF_W){1'b0}}, req_wdata[HALF_W-1:0]};
      rsp_valid_q <= beat_end && !act_wr;
      if (beat_end && !act_wr)
        rsp_data_q <= act_cfg.wide ? mem_rdata
                                   : {{(DATA_W-HALF_W){1'b0}}, mem_rdata[HALF_W-1:0]};
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/smc_bank_seq_chk.sv
module smc_bank_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int OFS_W     = 16,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [NUM_BANKS-1:0] mem_cs_n,
  input logic                 mem_oe_n,
  input logic                 mem_we_n,
  input logic [OFS_W-1:0]     mem_addr,
  input logic [DATA_W-1:0]    mem_wdata,
  input logic                 mem_data_oe
);

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_data_oe));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R3
  strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  write_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_data_oe && $past(mem_data_oe)) |-> ($stable(mem_wdata) && $stable(mem_addr)));

endmodule

bind smc_bank_seq smc_bank_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_cs_n    (mem_cs_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_data_oe (mem_data_oe)
);

// File: tb/smc_bank_seq_bench.sv
`timescale 1ns/1ps
module smc_bank_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [26:0] cfg_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [15:0] req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_data_oe;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  smc_bank_seq u_smc_bank_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_data_oe(mem_data_oe), .mem_rdata(mem_rdata)
  );

  // External memory model: data is a fixed function of the address.
  function automatic logic [15:0] mem_fn(logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h31};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  typedef struct packed {
    logic [3:0]  cs;
    logic        oe;
    logic        we;
    logic [15:0] ad;
    logic [15:0] wd;
    logic        doe;
    logic        rdy;
    logic        rv;
    logic [15:0] rd;
  } ent_t;

  ent_t        expq[$];
  logic [26:0] mcfg [4];
  int          checks = 0;
  int          errors = 0;
  bit          run = 0;
  bit          done = 0;
  string       cur_tag = "reset";

  function automatic ent_t idle_ent();
    ent_t e;
    e = '0;
    e.cs = 4'hF; e.oe = 1'b1; e.we = 1'b1; e.rdy = 1'b1;
    return e;
  endfunction

  // Field layout per R2: {wide, page, P, D, H, C, S, A}
  function automatic logic [26:0] mk(bit wide, bit pg, int tpg, int tah, int tch,
                                     int tcs, int tas, int tacc);
    return {wide, pg, 4'(tpg), 4'(tah), 4'(tch), 4'(tcs), 4'(tas), 5'(tacc)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%h expected=%h at %0t", req, what, cur_tag, act, exp, $time);
    end
  endtask

  // Behavioural per-cycle trace of one transaction, from R3, R5 to R8, R11.
  task automatic build_trace(bit wr, int bank, int ofs, int wdat);
    logic [26:0] w;
    int tacc, tas, tcs, tch, tah, tpg, items, step, n;
    bit pg, wide;
    logic [15:0] a, mask;
    ent_t e, tmp;
    ent_t tr[$];
    int ridx[$];
    logic [15:0] rdv[$];
    w = mcfg[bank];
    tacc = int'(w[4:0]); tas = int'(w[8:5]); tcs = int'(w[12:9]);
    tch = int'(w[16:13]); tah = int'(w[20:17]); tpg = int'(w[24:21]);
    pg = w[25]; wide = w[26];
    mask  = wide ? 16'hFFFF : 16'h00FF;
    step  = wide ? 2 : 1;
    items = (!wr && pg) ? 4 : 1;   // R11: writes stay single
    tr.push_back(idle_ent());
    e = '0;
    e.cs = 4'hF; e.oe = 1'b1; e.we = 1'b1;
    e.ad = 16'(ofs); e.wd = wr ? (16'(wdat) & mask) : 16'h0; e.doe = wr;
    repeat (tas) tr.push_back(e);
    e.cs = ~(4'b0001 << bank);
    repeat (tcs) tr.push_back(e);
    for (int k = 0; k < items; k++) begin
      n = (k == 0) ? tacc + 1 : ((tpg == 0) ? 1 : tpg);
      a = 16'(ofs + k * step);
      e.ad = a; e.oe = wr; e.we = !wr;
      repeat (n) tr.push_back(e);
      if (!wr) begin
        ridx.push_back(tr.size());
        rdv.push_back(mem_fn(a) & mask);
      end
    end
    e.oe = 1'b1; e.we = 1'b1;
    repeat (tch) tr.push_back(e);
    e.cs = 4'hF;
    repeat (tah) tr.push_back(e);
    tr.push_back(idle_ent());
    foreach (ridx[i]) begin
      tmp = tr[ridx[i]];
      tmp.rv = 1'b1; tmp.rd = rdv[i];
      tr[ridx[i]] = tmp;
    end
    foreach (tr[i]) expq.push_back(tr[i]);
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    ent_t x;
    if (run && !done) begin
      x = (expq.size() != 0) ? expq.pop_front() : idle_ent();
      chk(mem_cs_n == x.cs, "R4", "cs_n", 32'(mem_cs_n), 32'(x.cs));
      chk({mem_oe_n, mem_we_n} == {x.oe, x.we}, "R3", "oe_n/we_n",
          32'({mem_oe_n, mem_we_n}), 32'({x.oe, x.we}));
      chk(mem_addr == x.ad, "R7", "addr", 32'(mem_addr), 32'(x.ad));
      chk({mem_data_oe, mem_wdata} == {x.doe, x.wd}, "R5", "wdata",
          32'({mem_data_oe, mem_wdata}), 32'({x.doe, x.wd}));
      chk(req_ready == x.rdy, "R9", "ready", 32'(req_ready), 32'(x.rdy));
      chk(rsp_valid == x.rv && (!x.rv || rsp_data == x.rd), "R6", "rsp",
          32'({rsp_valid, rsp_data}), 32'({x.rv, x.rd}));
    end
  end

  task automatic cfg_wr(int b, logic [26:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_word = w;
    mcfg[b] = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk); #1;
    while (expq.size() != 0) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic issue(bit wr, int b, int ofs, int wdat, string tag);
    drain();
    cur_tag = tag;
    build_trace(wr, b, ofs, wdat);
    req_valid = 1'b1; req_write = wr; req_bank = 2'(b);
    req_offset = 16'(ofs); req_wdata = 16'(wdat);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 4; b++) mcfg[b] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1;
    @(negedge clk); #1;
    // R1: quiet state after reset
    chk(req_ready && mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !mem_data_oe &&
        !rsp_valid && mem_addr == 16'h0, "R1", "reset state",
        32'({req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_data_oe, rsp_valid}),
        32'(9'b1_1111_1100));

    // R2, R3: every phase present, narrow bank
    cfg_wr(0, mk(0, 0, 0, 1, 1, 1, 2, 2));
    issue(0, 0, 16'h0010, 0, "R3 read bank0");
    // R5, R8: narrow write clears upper byte
    issue(1, 0, 16'h0020, 16'hBEEF, "R5 write bank0");
    // R3: all counts zero, phases skipped
    issue(0, 1, 16'h0003, 0, "R3 zero counts read");
    issue(1, 1, 16'h0004, 16'h1234, "R3 zero counts write");
    // R7, R8: wide page read with step 2
    cfg_wr(2, mk(1, 1, 2, 1, 0, 0, 1, 3));
    issue(0, 2, 16'h0100, 0, "R7 wide page read");
    // R11: write on page bank moves one item
    issue(1, 2, 16'h0200, 16'hA55A, "R11 page bank write");
    // R7: page count zero counts as one, max counts, address wrap
    cfg_wr(3, mk(0, 1, 0, 15, 15, 15, 15, 31));
    issue(0, 3, 16'hFFFE, 0, "R7 max counts page read");
    // R6: back-to-back response pulses, response in trailing idle cycle
    cfg_wr(1, mk(1, 1, 1, 0, 0, 0, 0, 0));
    issue(0, 1, 16'h0040, 0, "R6 dense page read");

    // R10: configuration write during the bank's own transaction
    issue(0, 0, 16'h0030, 0, "R10 before update");
    cfg_wr(0, mk(1, 0, 0, 0, 2, 0, 0, 4));
    issue(0, 0, 16'h0032, 0, "R10 after update");

    // R9: request held valid while busy is ignored
    issue(0, 3, 16'h0050, 0, "R9 busy ignore");
    req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd1;
    req_offset = 16'h7777; req_wdata = 16'h9999;
    repeat (5) @(posedge clk);
    #1 req_valid = 1'b0;

    // R4: each bank line in turn
    for (int b = 0; b < 4; b++) issue(1, b, 16'h0008 + b, 16'h0F00 + b, "R4 bank sweep");
    drain();
    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired [%s]", cur_tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule